// File: doc/BRIEF.md
# Vector Mask Set-First Unit

This block turns a source mask vector into a destination mask vector. One bit stands for each element. It finds the first active element whose source bit is set and fills the destination around that position. Three fill modes are available. Set-before marks every active element that comes ahead of the first set bit. Set-including marks the same elements plus the first set bit itself. Set-only marks the first set bit and nothing else.

The unit takes a full 32-bit instruction word and decodes it itself. The word selects the fill mode and says whether the governing mask applies. An element whose governing bit is clear is left out of the search and is not written. Elements from the active length vl up to the element limit form the tail, and the tail is written with zeros. The result comes out as a data vector and a per-element write-enable vector, so a register file can merge it into the old destination contents. Both vectors are registered one cycle after the start strobe, which is also when the done pulse appears.

Top module: `msf_unit`

## Requirements
- R1: The instruction is legal only when bits [6:0] = 1010111, bits [14:12] = 010, bits [31:26] = 010110, and bits [19:15] hold one of three mode codes: 00001 for set-before, 00011 for set-including, 00010 for set-only. Bit 25 = 1 makes every element active whatever its governing bit.
- R2: Set-before writes 1 to active elements ahead of the first active set source bit, and writes 0 at that bit.
- R3: Set-including writes 1 to active elements ahead of the first active set source bit, and also writes 1 at that bit.
- R4: Set-only writes 1 at the first active set source bit only, so at most one destination bit is 1.
- R5: When bit 25 is 0, an element whose governing bit is 0 is inactive. The search skips it and its write-enable is 0. A destination bit whose write-enable is 0 reads 0.
- R6: Every active element after the first active set source bit and below vl is written with 0 in all modes.
- R7: Elements with vl <= i < vlmax get write-enable 1 and data 0. Elements at i >= vlmax are never written.
- R8: When vl is 0, every write-enable bit is 0.
- R9: When no active source bit is set, set-before and set-including write 1 to every active element below vl, and set-only writes 0 to them.
- R10: An illegal instruction drives the illegal flag to 1 and forces every write-enable bit to 0.
- R11: The outputs update on the clock edge that samples start high, and done is high for exactly the following cycle. While start is low, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture strobe; the result is registered on this edge |
| instr | input | 32 | Instruction word carrying the mode and the masking-disable bit |
| src_mask | input | N | Source mask, one bit per element |
| gov_mask | input | N | Governing mask, one bit per element |
| vl | input | CW | Active length |
| vlmax | input | CW | Element limit; the tail ends here |
| dest_mask | output | N | Registered destination data |
| dest_we | output | N | Registered per-element write-enable |
| illegal | output | 1 | Registered illegal-instruction flag |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench builds two copies of the block with N = 16. One copy uses the logarithmic prefix tree and the other uses the ripple chain. Both copies are checked against the same expected values, so the two generate variants are confirmed to agree. With N = 16, CW is 5 bits, which lets the bench reach the full-length case vl = N, a vlmax below vl, and the last-element first-set position without long vectors.

// File: rtl/msf_pkg.sv
package msf_pkg;

   typedef enum logic [1:0] {
      SF_BEFORE = 2'd0,
      SF_INCL   = 2'd1,
      SF_ONLY   = 2'd2
   } sf_mode_e;

   localparam logic [6:0] SF_OPCODE = 7'b1010111;
   localparam logic [2:0] SF_FUNCT3 = 3'b010;
   localparam logic [5:0] SF_FUNCT6 = 6'b010110;

   localparam logic [4:0] SF_SEL_BEFORE = 5'b00001;
   localparam logic [4:0] SF_SEL_INCL   = 5'b00011;
   localparam logic [4:0] SF_SEL_ONLY   = 5'b00010;

endpackage

// File: rtl/msf_decode.sv
module msf_decode
   import msf_pkg::*;
(
   input  logic [31:0] instr,
   output sf_mode_e    mode,
   output logic        mask_off,
   output logic        illegal
);

   logic sel_ok;
   logic fmt_ok;

   always_comb begin
      mode   = SF_BEFORE;
      sel_ok = 1'b1;
      case (instr[19:15])
         SF_SEL_BEFORE: mode = SF_BEFORE;
         SF_SEL_INCL:   mode = SF_INCL;
         SF_SEL_ONLY:   mode = SF_ONLY;
         default:       sel_ok = 1'b0;
      endcase
   end

   assign fmt_ok   = (instr[6:0] == SF_OPCODE) && (instr[14:12] == SF_FUNCT3) &&
                     (instr[31:26] == SF_FUNCT6);
   assign illegal  = !(fmt_ok && sel_ok);
   assign mask_off = instr[25];

endmodule

// File: rtl/msf_window.sv
module msf_window #(
   parameter int N  = 64,
   parameter int CW = $clog2(N + 1)
) (
   input  logic          mask_off,
   input  logic [N-1:0]  gov,
   input  logic [CW-1:0] vl,
   input  logic [CW-1:0] vlmax,
   output logic [N-1:0]  act,
   output logic [N-1:0]  tail
);

   for (genvar i = 0; i < N; i++) begin : g_elem
      logic below_vl;
      logic below_max;
      assign below_vl  = CW'(i) < vl;
      assign below_max = CW'(i) < vlmax;
      assign act[i]    = below_vl && below_max && (mask_off || gov[i]);
      assign tail[i]   = (vl != '0) && !below_vl && below_max;
   end

endmodule

// File: rtl/msf_prefix.sv
module msf_prefix #(
   parameter int N        = 64,
   parameter bit LOG_TREE = 1'b1
) (
   input  logic [N-1:0] hit,
   output logic [N-1:0] found
);

   if (LOG_TREE) begin : g_tree
      logic [N-1:0] acc;
      always_comb begin
         acc = hit;
         for (int s = 1; s < N; s = s * 2) begin
            acc = acc | (acc << s);
         end
      end
      assign found = {acc[N-2:0], 1'b0};
   end else begin : g_ripple
      logic [N-1:0] chain;
      logic         run;
      always_comb begin
         run = 1'b0;
         for (int i = 0; i < N; i++) begin
            chain[i] = run;
            run      = run | hit[i];
         end
      end
      assign found = chain;
   end

endmodule

// File: rtl/msf_select.sv
module msf_select
   import msf_pkg::*;
#(
   parameter int N = 64
) (
   input  sf_mode_e     mode,
   input  logic         illegal,
   input  logic [N-1:0] src,
   input  logic [N-1:0] act,
   input  logic [N-1:0] tail,
   input  logic [N-1:0] found,
   output logic [N-1:0] dest,
   output logic [N-1:0] we
);

   logic [N-1:0] lead;
   logic [N-1:0] first;
   logic [N-1:0] fill;

   assign lead  = act & ~found;
   assign first = lead & src;

   always_comb begin
      case (mode)
         SF_BEFORE: fill = lead & ~src;
         SF_INCL:   fill = lead;
         default:   fill = first;
      endcase
   end

   assign dest = illegal ? '0 : fill;
   assign we   = illegal ? '0 : (act | tail);

endmodule

// File: rtl/msf_unit.sv
module msf_unit
   import msf_pkg::*;
#(
   parameter int N        = 64,
   parameter bit LOG_TREE = 1'b1,
   parameter int CW       = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [31:0]   instr,
   input  logic [N-1:0]  src_mask,
   input  logic [N-1:0]  gov_mask,
   input  logic [CW-1:0] vl,
   input  logic [CW-1:0] vlmax,
   output logic [N-1:0]  dest_mask,
   output logic [N-1:0]  dest_we,
   output logic          illegal,
   output logic          done
);

   if (N < 2) begin : g_bad_n
      $error("msf_unit: N must be at least 2");
   end
   if (CW < $clog2(N + 1)) begin : g_bad_cw
      $error("msf_unit: CW too narrow to hold N");
   end

   sf_mode_e     mode;
   logic         mask_off;
   logic         ill_c;
   logic [N-1:0] act;
   logic [N-1:0] tail;
   logic [N-1:0] found;
   logic [N-1:0] dest_c;
   logic [N-1:0] we_c;

   msf_decode u_dec (
      .instr    (instr),
      .mode     (mode),
      .mask_off (mask_off),
      .illegal  (ill_c)
   );

   msf_window #(.N(N), .CW(CW)) u_win (
      .mask_off (mask_off),
      .gov      (gov_mask),
      .vl       (vl),
      .vlmax    (vlmax),
      .act      (act),
      .tail     (tail)
   );

   msf_prefix #(.N(N), .LOG_TREE(LOG_TREE)) u_pfx (
      .hit   (src_mask & act),
      .found (found)
   );

   msf_select #(.N(N)) u_sel (
      .mode    (mode),
      .illegal (ill_c),
      .src     (src_mask),
      .act     (act),
      .tail    (tail),
      .found   (found),
      .dest    (dest_c),
      .we      (we_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_mask <= '0;
         dest_we   <= '0;
         illegal   <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            dest_mask <= dest_c;
            dest_we   <= we_c;
            illegal   <= ill_c;
         end
      end
   end

   assert_done_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(dest_mask) && $stable(dest_we)));
   assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (dest_we == '0));
   assert_vl_zero_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && vl == '0) |=> (dest_we == '0));
   assert_only_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == SF_ONLY) |=> $onehot0(dest_mask));
   assert_unwritten_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_mask & ~dest_we) == '0);
   assert_found_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ((found[N-2:0] & ~found[N-1:1]) == '0));

endmodule

// File: tb/msf_unit_bench.sv
`timescale 1ns/1ps
module msf_unit_bench;
   localparam int N  = 16;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   instr = '0;
   logic [N-1:0]  src_mask = '0;
   logic [N-1:0]  gov_mask = '0;
   logic [CW-1:0] vl = '0;
   logic [CW-1:0] vlmax = '0;
   logic [N-1:0]  d_a, we_a, d_b, we_b;
   logic          ill_a, ill_b, dn_a, dn_b;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   msf_unit #(.N(N), .LOG_TREE(1'b1), .CW(CW)) u_msf_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .src_mask(src_mask), .gov_mask(gov_mask), .vl(vl), .vlmax(vlmax),
      .dest_mask(d_a), .dest_we(we_a), .illegal(ill_a), .done(dn_a));

   msf_unit #(.N(N), .LOG_TREE(1'b0), .CW(CW)) u_msf_unit_rip (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .src_mask(src_mask), .gov_mask(gov_mask), .vl(vl), .vlmax(vlmax),
      .dest_mask(d_b), .dest_we(we_b), .illegal(ill_b), .done(dn_b));

   // Stimulus: {vs1[4:0], mask_off, vl[4:0], vlmax[4:0], src[15:0], gov[15:0]}
   localparam int NV = 9;
   localparam logic [47:0] VEC [NV] = '{
      {5'b00001, 1'b1, 5'd16, 5'd16, 16'h0010, 16'h0000},  // R2 set-before
      {5'b00011, 1'b1, 5'd16, 5'd16, 16'h0010, 16'h0000},  // R3 set-including
      {5'b00010, 1'b1, 5'd16, 5'd16, 16'h0110, 16'h0000},  // R4 R6 set-only
      {5'b00001, 1'b0, 5'd16, 5'd16, 16'h0030, 16'hFFEF},  // R5 skip inactive
      {5'b00011, 1'b1, 5'd10, 5'd16, 16'h0800, 16'h0000},  // R7 R9 set bit in tail
      {5'b00010, 1'b1, 5'd12, 5'd16, 16'h0000, 16'h0000},  // R9 set-only none
      {5'b00001, 1'b1, 5'd0,  5'd16, 16'h00FF, 16'h0000},  // R8 vl zero
      {5'b00111, 1'b1, 5'd16, 5'd16, 16'h0001, 16'h0000},  // R10 bad mode code
      {5'b00010, 1'b0, 5'd16, 5'd12, 16'h00A5, 16'h00F0}   // R5 R7 vlmax below vl
   };

   function automatic logic [31:0] mk_instr(input logic [4:0] sel, input logic moff);
      return {6'b010110, moff, 5'd2, sel, 3'b010, 5'd3, 7'b1010111};
   endfunction

   // Model built from the requirements, element by element.
   function automatic logic [2*N:0] model(input logic [31:0] ins, input logic [N-1:0] s,
                                          input logic [N-1:0] g, input int l, input int lm);
      logic [N-1:0] d, w;
      logic bad, hitf;
      int   m;
      d = '0; w = '0; hitf = 1'b0;
      m = (ins[19:15] == 5'b00001) ? 0 : (ins[19:15] == 5'b00011) ? 1 :
          (ins[19:15] == 5'b00010) ? 2 : 3;
      bad = (ins[6:0] != 7'b1010111) || (ins[14:12] != 3'b010) ||
            (ins[31:26] != 6'b010110) || (m == 3);
      if (!bad) begin
         for (int i = 0; i < N; i++) begin
            if (i < l && i < lm && (ins[25] || g[i])) begin
               w[i] = 1'b1;
               if (hitf) d[i] = 1'b0;
               else if (s[i]) begin hitf = 1'b1; d[i] = (m != 0); end
               else d[i] = (m != 2);
            end else if (l != 0 && i >= l && i < lm) begin
               w[i] = 1'b1;
            end
         end
      end
      return {bad, w, d};
   endfunction

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run(input string tag, input logic [31:0] ins, input logic [N-1:0] s,
                      input logic [N-1:0] g, input int l, input int lm);
      logic [2*N:0] e;
      e = model(ins, s, g, l, lm);
      @(negedge clk);
      instr = ins; src_mask = s; gov_mask = g;
      vl = CW'(l); vlmax = CW'(lm); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R11 done"}, N'({dn_a, dn_b}), N'(2'b11));
      chk({tag, " dest"}, d_a, e[N-1:0]);
      chk({tag, " we"}, we_a, e[2*N-1:N]);
      chk({tag, " R10 illegal"}, N'(ill_a), N'(e[2*N]));
      chk({tag, " ripple dest"}, d_b, e[N-1:0]);
      chk({tag, " ripple we"}, we_b, e[2*N-1:N]);
      src_mask = ~s; gov_mask = ~g;
      @(negedge clk);
      chk({tag, " R11 done drop"}, N'({dn_a, dn_b}), '0);
      chk({tag, " R11 hold"}, d_a, e[N-1:0]);
   endtask

   logic finished = 1'b0;

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("reset dest", d_a, '0);
      chk("reset we", we_a, '0);
      chk("reset done R11", N'({dn_a, ill_a}), '0);
      rst_n = 1'b1;
      for (int k = 0; k < NV; k++) begin
         run($sformatf("vec%0d R1", k), mk_instr(VEC[k][47:43], VEC[k][42]),
             VEC[k][31:16], VEC[k][15:0], int'(VEC[k][41:37]), int'(VEC[k][36:32]));
      end
      // R10 wrong major opcode
      run("bad opcode R10", mk_instr(5'b00001, 1'b1) ^ 32'h1, 16'h0004, 16'h0, 16, 16);
      // R2 first set bit at the last element
      run("last element R2", mk_instr(5'b00001, 1'b1), 16'h8000, 16'h0, 16, 16);
      // R3 first set bit at element zero
      run("element zero R3", mk_instr(5'b00011, 1'b1), 16'h0001, 16'h0, 16, 16);
      // R9 set-before, nothing set, governing mask sparse
      run("none set R9", mk_instr(5'b00001, 1'b0), 16'h0000, 16'h5555, 9, 16);
      // R6 set-only with set bit shadowed by an inactive element
      run("shadowed R6", mk_instr(5'b00010, 1'b0), 16'h0606, 16'h0FFD, 16, 16);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule